// File: doc/BRIEF.md
# Accumulator ALU with Flag Register and Branch Condition Select

This block is the arithmetic unit of a small accumulator machine. Two operands arrive each cycle: `x_i` is the accumulator value and `y_i` is the second operand held in the B register. A two-bit operation code picks one of four actions: do nothing, compare, add, or subtract. Add and subtract present their result on `result_o` and raise `acc_we_o` so the sequencer writes the accumulator. Compare and do-nothing pass `x_i` through unchanged and keep `acc_we_o` low.

A five-bit flag register records negative, carry/borrow, greater, equal and less conditions. Add and subtract write the negative and carry flags. Compare writes the three ordering flags from a signed comparison. Each flag group is written only by its own operations, and do-nothing writes no flag.

A two-bit condition select picks one stored flag. The choice is gated by a read strobe to form `branch_take_o`, which the sequencer uses to allow the program-counter load for a conditional jump. The block works in the same cycle as its inputs and has no handshake: the sequencer presents one operation per cycle. Flag updates become visible one clock after the operation.

Top module: `alu_branch_unit`

## Requirements
- R1: With op code 2'b10 (add), `result_o` equals `x_i + y_i` modulo 2^16 in the same cycle and `acc_we_o` is 1.
- R2: With op code 2'b11 (subtract), `result_o` equals `x_i - y_i` modulo 2^16 in the same cycle and `acc_we_o` is 1.
- R3: With op code 2'b00 (no operation) or 2'b01 (compare), `acc_we_o` is 0 and `result_o` equals `x_i`.
- R4: `flags_o` is {N, C, G, E, L} with N at bit 4, C at bit 3, G at bit 2, E at bit 1 and L at bit 0. After an add, from the next clock on, N is bit 15 of the sum and C is the carry out of bit 15.
- R5: After a subtract, from the next clock on, N is bit 15 of the difference and C is 1 exactly when `x_i` < `y_i` as unsigned values (borrow).
- R6: After a compare, from the next clock on, G, E and L give signed `x_i` > `y_i`, `x_i` == `y_i` and `x_i` < `y_i`; exactly one of them is 1, and N and C are unchanged.
- R7: Add and subtract leave G, E and L unchanged.
- R8: The no-operation code changes no flag.
- R9: With `flag_rd_i` = 1, `branch_take_o` shows the stored flag picked by `flag_sel_i`: 2'b00 selects N, 2'b01 selects G, 2'b10 selects E and 2'b11 selects L. The path is combinational from the stored flags.
- R10: With `flag_rd_i` = 0, `branch_take_o` is 0 whatever the flags and select.
- R11: Asynchronous active-low reset clears all five flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 00 none, 01 compare, 10 add, 11 subtract |
| x_i | input | 16 | Accumulator operand |
| y_i | input | 16 | B-register operand |
| flag_sel_i | input | 2 | Condition select for the branch output |
| flag_rd_i | input | 1 | Strobe that lets the selected flag reach the branch output |
| result_o | output | 16 | Value for the accumulator |
| acc_we_o | output | 1 | Accumulator write enable |
| flags_o | output | 5 | Stored flags {N, C, G, E, L} |
| branch_take_o | output | 1 | Branch condition, gated by the strobe |

## Verification
Directed operand pairs separate signed from unsigned ordering. For example, 0x8000 against 0x0001 must give L from a compare and no borrow from a subtract. Wrap-around sums test the carry flag, and equal operands test E. Interleaved compare, arithmetic and no-operation cycles show whether each flag group is written only by its own operations. A sweep of every select value, with the strobe both high and low, checks the branch mux against a known flag state. A long pseudo-random run against the behavioural model covers the remaining operand and operation mixes.

// File: rtl/alu_branch_pkg.sv
package alu_branch_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CMP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_NEG  = 2'b00,
    SEL_GT   = 2'b01,
    SEL_EQ   = 2'b10,
    SEL_LT   = 2'b11
  } cond_sel_e;

  typedef struct packed {
    logic neg;
    logic cy;
    logic gt;
    logic eq;
    logic lt;
  } flag_set_t;

  localparam int unsigned FLAG_COUNT = 5;
endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_branch_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic              wr_arith_o,
  output logic              wr_order_o,
  output flag_set_t         next_o
);
  localparam int unsigned EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] sum_ext;
  logic [EXT_W-1:0] dif_ext;
  logic             s_gt;
  logic             s_eq;

  always_comb begin
    sum_ext = {1'b0, x_i} + {1'b0, y_i};
    dif_ext = {1'b0, x_i} - {1'b0, y_i};
    s_eq    = (x_i == y_i);
    s_gt    = ($signed(x_i) > $signed(y_i));
  end

  always_comb begin
    result_o   = x_i;
    acc_we_o   = 1'b0;
    wr_arith_o = 1'b0;
    wr_order_o = 1'b0;
    next_o     = '0;
    unique case (alu_op_e'(op_i))
      OP_ADD: begin
        result_o   = sum_ext[DATA_W-1:0];
        acc_we_o   = 1'b1;
        wr_arith_o = 1'b1;
        next_o.neg = sum_ext[DATA_W-1];
        next_o.cy  = sum_ext[DATA_W];
      end
      OP_SUB: begin
        result_o   = dif_ext[DATA_W-1:0];
        acc_we_o   = 1'b1;
        wr_arith_o = 1'b1;
        next_o.neg = dif_ext[DATA_W-1];
        next_o.cy  = dif_ext[DATA_W];
      end
      OP_CMP: begin
        wr_order_o = 1'b1;
        next_o.gt  = s_gt;
        next_o.eq  = s_eq;
        next_o.lt  = !s_gt && !s_eq;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
  import alu_branch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_arith_i,
  input  logic      wr_order_i,
  input  flag_set_t next_i,
  output flag_set_t flags_o
);
  flag_set_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      if (wr_arith_i) begin
        state_q.neg <= next_i.neg;
        state_q.cy  <= next_i.cy;
      end
      if (wr_order_i) begin
        state_q.gt <= next_i.gt;
        state_q.eq <= next_i.eq;
        state_q.lt <= next_i.lt;
      end
    end
  end

  assign flags_o = state_q;
endmodule

// File: rtl/alu_cond_mux.sv
module alu_cond_mux
  import alu_branch_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  flag_set_t        flags_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rd_i,
  output logic             take_o
);
  localparam int unsigned LEGS = 1 << SEL_W;

  logic [LEGS-1:0] leg;

  always_comb begin
    leg                  = '0;
    leg[SEL_NEG]         = flags_i.neg;
    leg[SEL_GT]          = flags_i.gt;
    leg[SEL_EQ]          = flags_i.eq;
    leg[SEL_LT]          = flags_i.lt;
    take_o               = rd_i & leg[sel_i];
  end
endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import alu_branch_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            op_i,
  input  logic [DATA_W-1:0]     x_i,
  input  logic [DATA_W-1:0]     y_i,
  input  logic [SEL_W-1:0]      flag_sel_i,
  input  logic                  flag_rd_i,
  output logic [DATA_W-1:0]     result_o,
  output logic                  acc_we_o,
  output logic [FLAG_COUNT-1:0] flags_o,
  output logic                  branch_take_o
);
  logic      wr_arith;
  logic      wr_order;
  flag_set_t next_flags;
  flag_set_t cur_flags;

  alu_arith_core #(.DATA_W(DATA_W)) u_core (
    .op_i       (op_i),
    .x_i        (x_i),
    .y_i        (y_i),
    .result_o   (result_o),
    .acc_we_o   (acc_we_o),
    .wr_arith_o (wr_arith),
    .wr_order_o (wr_order),
    .next_o     (next_flags)
  );

  alu_flag_store u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_arith_i (wr_arith),
    .wr_order_i (wr_order),
    .next_i     (next_flags),
    .flags_o    (cur_flags)
  );

  alu_cond_mux #(.SEL_W(SEL_W)) u_mux (
    .flags_i (cur_flags),
    .sel_i   (flag_sel_i),
    .rd_i    (flag_rd_i),
    .take_o  (branch_take_o)
  );

  assign flags_o = cur_flags;
endmodule

// File: rtl/alu_branch_chk.sv
module alu_branch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_i,
  input logic [15:0] x_i,
  input logic [15:0] result_o,
  input logic        acc_we_o,
  input logic [4:0]  flags_o,
  input logic        flag_rd_i,
  input logic        branch_take_o
);
  // R3: no accumulator write on none/compare, value passes through
  p_no_acc_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[1] == 1'b0) |-> (!acc_we_o && result_o == x_i));

  // R6: compare leaves exactly one ordering flag set
  p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01) |=> ($countones(flags_o[2:0]) == 1));

  // R6: compare keeps N and C
  p_cmp_keeps_nc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b01) |=> $stable(flags_o[4:3]));

  // R4: stored N follows the sign of the add result
  p_add_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b10) |=> (flags_o[4] == $past(result_o[15])));

  // R7: arithmetic keeps the ordering flags
  p_arith_keeps_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[1] == 1'b1) |=> $stable(flags_o[2:0]));

  // R8: no-operation holds all flags
  p_none_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00) |=> $stable(flags_o));

  // R10: strobe low blocks the branch output
  p_rd_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_rd_i |-> !branch_take_o);
endmodule

bind alu_branch_unit alu_branch_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_i          (op_i),
  .x_i           (x_i),
  .result_o      (result_o),
  .acc_we_o      (acc_we_o),
  .flags_o       (flags_o),
  .flag_rd_i     (flag_rd_i),
  .branch_take_o (branch_take_o)
);

// File: tb/alu_branch_unit_tb.sv
`timescale 1ns/1ps
module alu_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] x_i = '0;
  logic [15:0] y_i = '0;
  logic [1:0]  flag_sel_i = 2'b00;
  logic        flag_rd_i = 1'b0;
  logic [15:0] result_o;
  logic        acc_we_o;
  logic [4:0]  flags_o;
  logic        branch_take_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [4:0] mf = '0;   // model flags {N,C,G,E,L}

  always #2.5 clk = ~clk;

  alu_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_i(y_i),
    .flag_sel_i(flag_sel_i), .flag_rd_i(flag_rd_i), .result_o(result_o),
    .acc_we_o(acc_we_o), .flags_o(flags_o), .branch_take_o(branch_take_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string flag_tag(input logic [1:0] op);
    case (op)
      2'b10: return "R4 R7";
      2'b11: return "R5 R7";
      2'b01: return "R6";
      default: return "R8";
    endcase
  endfunction

  // One cycle: drive at negedge, compare combinational outputs, clock, compare flags.
  task automatic step(input logic [1:0] op, input logic [15:0] x, input logic [15:0] y,
                      input logic [1:0] sel, input logic rd);
    logic [16:0] s;
    logic [15:0] exp_res;
    logic        exp_we;
    logic        exp_br;
    @(negedge clk);
    op_i = op; x_i = x; y_i = y; flag_sel_i = sel; flag_rd_i = rd;
    #1;
    exp_res = x; exp_we = 1'b0;
    if (op == 2'b10) begin exp_res = x + y; exp_we = 1'b1; end
    if (op == 2'b11) begin exp_res = x - y; exp_we = 1'b1; end
    chk(op == 2'b10 ? "R1" : op == 2'b11 ? "R2" : "R3", {16'd0, result_o}, {16'd0, exp_res});
    chk(op[1] ? "R1 R2 acc_we" : "R3 acc_we", {31'd0, acc_we_o}, {31'd0, exp_we});
    case (sel)
      2'b00: exp_br = mf[4];
      2'b01: exp_br = mf[2];
      2'b10: exp_br = mf[1];
      default: exp_br = mf[0];
    endcase
    exp_br = exp_br & rd;
    chk(rd ? "R9" : "R10", {31'd0, branch_take_o}, {31'd0, exp_br});
    @(posedge clk);
    case (op)
      2'b10: begin s = {1'b0, x} + {1'b0, y}; mf[4] = s[15]; mf[3] = s[16]; end
      2'b11: begin s = {1'b0, x} - {1'b0, y}; mf[4] = s[15]; mf[3] = (x < y); end
      2'b01: begin
        mf[2] = ($signed(x) > $signed(y));
        mf[1] = (x == y);
        mf[0] = ($signed(x) < $signed(y));
      end
      default: ;
    endcase
    #1;
    chk(flag_tag(op), {27'd0, flags_o}, {27'd0, mf});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset", {27'd0, flags_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 signed ordering: 0x8000 is negative, so less than 1
    step(2'b01, 16'h8000, 16'h0001, 2'b11, 1'b1);
    // R5 unsigned borrow is 0 for the same pair
    step(2'b11, 16'h8000, 16'h0001, 2'b00, 1'b1);
    // R4 carry out on wrap
    step(2'b10, 16'hFFFF, 16'h0002, 2'b00, 1'b1);
    // R5 borrow set
    step(2'b11, 16'h0001, 16'h0002, 2'b01, 1'b1);
    // R6 equal
    step(2'b01, 16'h1234, 16'h1234, 2'b10, 1'b1);
    // R8 none holds, R10 strobe low
    step(2'b00, 16'hAAAA, 16'h5555, 2'b10, 1'b0);
    // R6 greater, R7 add keeps ordering
    step(2'b01, 16'h0005, 16'hFFFB, 2'b01, 1'b1);
    step(2'b10, 16'h7FFF, 16'h0001, 2'b01, 1'b1);
    // R9 / R10 full select sweep on a fixed state
    for (int s = 0; s < 4; s++) begin
      step(2'b00, 16'h0, 16'h0, 2'(s), 1'b1);
      step(2'b00, 16'h0, 16'h0, 2'(s), 1'b0);
    end
    // Mixed pseudo-random run
    for (int i = 0; i < 2000; i++) begin
      step(2'($urandom), 16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule